// File: doc/BRIEF.md
# Gated Divided-Clock Pin-0 Output

This block sits between the general-purpose I/O logic of four peripheral slots and their pins. Each slot can drive pin 0 with a square wave derived from the master clock by integer division. A per-slot configuration word selects whether pin 0 carries this clock or the ordinary GPIO value. When the clock is off, the GPIO value for pin 0 passes straight through to the pin without delay.

Software writes each slot's word through a simple write port: a strobe, a slot number and a 32-bit data word. The low seven bits set the half-period in master-clock cycles and bit 7 selects the clock. Every write restarts that slot's divider from a low phase, so the phase of the output is defined relative to the write.

Top module: `refclk_pin_gate`

## Requirements
- R1: After a synchronous reset (rst_n low on a rising edge), every slot is disabled, and each pin0_out bit equals the matching gpio_pin0 bit.
- R2: A write takes effect only when wr_en is high on a rising clock edge. It changes only the slot numbered by wr_slot (0 to 3), and the new setting applies from that edge onward.
- R3: While bit 7 of a slot's word is 0, that slot's pin0_out follows its gpio_pin0 input combinationally, whatever the divisor.
- R4: With bit 7 set and a divisor N (bits 6:0) from 1 to 127, pin0_out is low from the write edge. It toggles on every Nth edge after that edge, which gives a period of 2N master-clock cycles.
- R5: With bit 7 set and a divisor of 0, pin0_out stays low.
- R6: Every write to a slot restarts its divider with the output low, even when the written value equals the stored one.
- R7: Bits 31:8 of wr_data are ignored. They are expected to be zero, and nonzero values change neither enable nor divisor.
- R8: A write to one slot does not disturb the phase or count of any other slot's running clock.
- R9: Clearing bit 7 returns pin 0 to the gpio_pin0 value from the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_slot | input | 2 | Slot number addressed by the write |
| wr_data | input | 32 | Configuration word: bit 7 enable, bits 6:0 divisor, bits 31:8 reserved |
| gpio_pin0 | input | 4 | Ordinary pin-0 value per slot |
| pin0_out | output | 4 | Final pin-0 level per slot |

## Verification
The embedded assertions check several properties on every cycle. A strobed write lands in exactly the addressed slot's register. A divider count never reaches its divisor. The divided clock rises only at the terminal count. A write forces the phase low. A zero divisor keeps the clock low. Exact toggle cycles for several divisors can only be shown by the bench's timed scenarios. The same applies to the combinational GPIO pass-through, to the return to GPIO on disable, to restarts on rewriting an identical value, and to slot independence while another slot is rewritten.

// File: rtl/refclk_pkg.sv
// Package: shared widths, field positions and the decoded per-slot
// configuration type for the gated pin-0 clock block.
// Assumes the configuration word keeps enable just above the divisor.
package refclk_pkg;
    localparam int DIV_W   = 7;
    localparam int EN_BIT  = DIV_W;
    localparam int FIELD_W = DIV_W + 1;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
    } slot_cfg_t;
endpackage

// File: rtl/refclk_cfg_reg.sv
// Module: one slot's configuration register.
// Captures the enable bit and divisor from a full-width write word when
// hit is high; reserved upper bits are discarded. Emits a one-cycle
// load pulse aligned with the capture edge so the divider can restart.
// Assumes a synchronous active-low reset.
module refclk_cfg_reg
    import refclk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    output slot_cfg_t         cfg,
    output logic              load
);
    logic unused_rsvd;

    // Reserved bits carry no function; fold them into a sink.
    assign unused_rsvd = &{1'b0, data[DATA_W-1:FIELD_W]};

    // Hold the decoded enable and divisor fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (hit) begin
            cfg.en  <= data[EN_BIT];
            cfg.div <= data[DIV_W-1:0];
        end
    end

    // Restart request is simply the write hit itself.
    assign load = hit;

    // R2/R7: a hit lands the low field bits only, from the next cycle.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg.en == $past(data[EN_BIT])) &&
                (cfg.div == $past(data[DIV_W-1:0])));

    // R2: without a hit the stored setting is unchanged.
    a_r2_hold_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cfg));
endmodule

// File: rtl/refclk_divider.sv
// Module: integer clock divider for one slot.
// Counts master-clock cycles and toggles its output every div cycles
// while enabled with a nonzero divisor; otherwise parks low. A load
// pulse clears the count and phase. Assumes div changes only with load.
module refclk_divider
    import refclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_cfg_t cfg,
    input  logic      load,
    output logic      div_clk
);
    logic [DIV_W-1:0] cnt;
    logic             run;
    logic             term;

    // Divider runs only with enable set and a nonzero divisor.
    assign run  = cfg.en && (cfg.div != '0);
    assign term = (cnt == cfg.div - DIV_W'(1));

    // Advance the count and flip the phase at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !run) begin
            cnt     <= '0;
            div_clk <= 1'b0;
        end else if (term) begin
            cnt     <= '0;
            div_clk <= ~div_clk;
        end else begin
            cnt     <= cnt + DIV_W'(1);
        end
    end

    // R4: the count stays below the divisor while running.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < cfg.div));

    // R4: a rising output only follows a terminal count while running.
    a_r4_rise_at_term: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> ($past(run) && ($past(cnt) == $past(cfg.div) - DIV_W'(1))));

    // R6: a load always restarts with the phase low.
    a_r6_load_restarts_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !div_clk);

    // R5: enable with a zero divisor keeps the clock parked low.
    a_r5_zero_div_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && (cfg.div == '0)) |=> !div_clk);
endmodule

// File: rtl/refclk_pin_mux.sv
// Module: pin-0 source selector for one slot.
// Chooses the divided clock when enabled, else passes the GPIO value
// straight through. Both selectors are registered upstream, so the
// choice changes only just after a clock edge.
module refclk_pin_mux (
    input  logic sel_clk,
    input  logic div_clk,
    input  logic gpio,
    output logic pin
);
    // Combinational pin source choice.
    always_comb begin
        pin = sel_clk ? div_clk : gpio;
    end
endmodule

// File: rtl/refclk_pin_gate.sv
// Module: top of the gated pin-0 clock block.
// Decodes the slot write port and instantiates, per slot, a config
// register, a divider and a pin mux. Assumes wr_slot is valid whenever
// wr_en is high and a synchronous active-low reset.
module refclk_pin_gate
    import refclk_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_SLOTS-1:0] gpio_pin0,
    output logic [NUM_SLOTS-1:0] pin0_out
);
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] load;
    logic [NUM_SLOTS-1:0] div_clk;
    slot_cfg_t            cfg [NUM_SLOTS];

    // One-hot slot decode of the write strobe.
    always_comb begin
        hit = '0;
        if (wr_en) hit[wr_slot] = 1'b1;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        refclk_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[s]),
            .data  (wr_data),
            .cfg   (cfg[s]),
            .load  (load[s])
        );

        refclk_divider u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg[s]),
            .load    (load[s]),
            .div_clk (div_clk[s])
        );

        refclk_pin_mux u_mux (
            .sel_clk (cfg[s].en),
            .div_clk (div_clk[s]),
            .gpio    (gpio_pin0[s]),
            .pin     (pin0_out[s])
        );
    end

    // R2/R8: at most one slot is addressed by any write.
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));
endmodule

// File: tb/refclk_pin_gate_tb.sv
module refclk_pin_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_slot = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  gpio_pin0 = '0;
    logic [3:0]  pin0_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    refclk_pin_gate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .gpio_pin0 (gpio_pin0),
        .pin0_out  (pin0_out)
    );

    typedef struct packed {
        logic [1:0]  slot;
        logic [31:0] data;
        logic        gpio;
        logic [7:0]  k;      // edges after the write edge before sampling
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_0000, 1'b1, 8'd0,   1'b1, 4'd3}, // R3 disabled passes gpio 1
        '{2'd0, 32'h0000_0000, 1'b0, 8'd3,   1'b0, 4'd3}, // R3 disabled passes gpio 0
        '{2'd1, 32'h0000_0083, 1'b1, 8'd0,   1'b0, 4'd4}, // R4 N=3 low at write
        '{2'd1, 32'h0000_0083, 1'b1, 8'd2,   1'b0, 4'd4}, // R4 still low before N
        '{2'd1, 32'h0000_0083, 1'b1, 8'd3,   1'b1, 4'd4}, // R4 high at N
        '{2'd1, 32'h0000_0083, 1'b1, 8'd5,   1'b1, 4'd4}, // R4 high until 2N
        '{2'd1, 32'h0000_0083, 1'b1, 8'd6,   1'b0, 4'd4}, // R4 low at 2N
        '{2'd2, 32'h0000_0081, 1'b1, 8'd1,   1'b1, 4'd4}, // R4 N=1 toggles every edge
        '{2'd2, 32'h0000_0081, 1'b1, 8'd2,   1'b0, 4'd4}, // R4 N=1 second edge
        '{2'd3, 32'h0000_0080, 1'b1, 8'd7,   1'b0, 4'd5}, // R5 zero divisor low
        '{2'd3, 32'hFFFF_FF05, 1'b1, 8'd2,   1'b1, 4'd7}, // R7 reserved set, bit7 clear
        '{2'd0, 32'hABCD_0082, 1'b0, 8'd2,   1'b1, 4'd7}, // R7 reserved set, N=2 runs
        '{2'd2, 32'h0000_00FF, 1'b1, 8'd126, 1'b0, 4'd4}, // R4 N=127 before edge
        '{2'd2, 32'h0000_00FF, 1'b1, 8'd127, 1'b1, 4'd4}  // R4 N=127 at edge
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pin0_out actual %b expected %b", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic write_slot(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_slot = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        gpio_pin0 = 4'b0101;
        edges(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state passes gpio on all slots
        check("R1", pin0_out, 4'b0101);
        gpio_pin0 = 4'b1010; #1;
        check("R1", pin0_out, 4'b1010);
        @(negedge clk);

        // Table walk: each vector rewrites its slot (restart) then waits k edges
        for (int v = 0; v < NV; v++) begin
            gpio_pin0 = {4{VECS[v].gpio}};
            write_slot(VECS[v].slot, VECS[v].data);
            edges(int'(VECS[v].k));
            #1;
            n_tests++;
            if (pin0_out[VECS[v].slot] !== VECS[v].exp) begin
                n_fail++;
                $display("FAIL R%0d vec %0d: pin0_out[%0d] actual %b expected %b",
                         VECS[v].req, v, VECS[v].slot, pin0_out[VECS[v].slot], VECS[v].exp);
            end
        end

        // Directed: reset again clears all slots
        rst_n = 1'b0; edges(2); rst_n = 1'b1;
        gpio_pin0 = 4'b0000;
        #1;
        check("R1", pin0_out, 4'b0000);

        // R8: slot0 N=4, then slot1 N=2 written two edges later
        write_slot(2'd0, 32'h84);      // E0
        edges(1);                      // E1
        write_slot(2'd1, 32'h82);      // E2
        #1;
        check("R8", pin0_out & 4'b0011, 4'b0000);
        edges(2);                      // E4
        #1;
        check("R8", pin0_out & 4'b0011, 4'b0011);

        // R6: rewriting the same value restarts slot0 low
        write_slot(2'd0, 32'h84);
        #1;
        check("R6", {3'b000, pin0_out[0]}, 4'b0000);
        edges(4);
        #1;
        check("R6", {3'b000, pin0_out[0]}, 4'b0001);

        // R9: disabling slot0 returns pin to gpio, combinational follow
        gpio_pin0[0] = 1'b0;
        write_slot(2'd0, 32'h04);
        #1;
        check("R9", {3'b000, pin0_out[0]}, 4'b0000);
        gpio_pin0[0] = 1'b1; #1;
        check("R9", {3'b000, pin0_out[0]}, 4'b0001);

        // R2: data presented without wr_en is not captured by slot3
        gpio_pin0[3] = 1'b1;
        wr_slot = 2'd3; wr_data = 32'h81; wr_en = 1'b0;
        edges(3);
        wr_data = '0;
        #1;
        check("R2", {pin0_out[3], 3'b000}, 4'b1000);

        // R2/R8: write to slot3 leaves slot1 (N=2) untouched; slot1 was loaded long ago
        write_slot(2'd3, 32'h00);
        #1;
        check("R2", {pin0_out[3], 3'b000}, 4'b1000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule